// File: doc/BRIEF.md
# Accumulator I/O controller core

An 8-bit control processor with no arithmetic unit. It runs a program from an external instruction memory addressed by an 11-bit program counter. Its working data live in a sixteen-entry register bank plus an accumulator. The accumulator can be incremented, decremented, shifted, complemented and compared with a register. Single accumulator bits can be set, cleared or tested. Input and output go through a 4-bit device-select port with read and write strobes, and through a set of direct control pins that software can set, clear and test.

Sequencing is a small state machine with three states. ST_FETCH latches the opcode and advances the PC, then always moves to ST_EXEC. ST_EXEC carries out the instruction, reading any operand byte from the instruction memory in that same cycle. From ST_EXEC the machine goes back to ST_FETCH, or it goes to ST_INTR when an interrupt request is pending and interrupts are not masked. ST_INTR saves the PC in the one-entry interrupt return slot, sets the mask, loads the fixed vector and returns to ST_FETCH. A separate one-entry slot holds the subroutine return address. The instruction memory is asynchronous: `rom_data` must reflect `rom_addr` within the same cycle.

Top module: `ioctl_core`

## Requirements
- R1: While reset is asserted and right after it is released, `rom_addr` is 0, `io_dout` (the accumulator) is 0, `dctl_out` is 0, `dev_sel` is 0 and both strobes are low. All registers read 0 and interrupts are unmasked.
- R2: Each instruction takes one fetch clock and one execute clock. The fetch advances `rom_addr` by one. A one-byte instruction leaves the PC unchanged during its execute clock. Opcode 0xF0 is a no-operation.
- R3: Two-byte instructions take the operand byte at the PC during their execute clock and finish in the same two clocks. Their PC ends two past the opcode.
- R4: Accumulator opcodes: 0x01 increment, 0x02 decrement (both wrap modulo 256), 0x03 shift left with 0 in, 0x04 logical shift right with 0 in, 0x05 bitwise complement.
- R5: Register access uses register index r = low nibble. 0x1r loads r into the accumulator, 0x2r stores the accumulator into r, and 0x9r,imm writes imm into r. 0xA0,imm loads imm into the accumulator. 0xBr loads the accumulator from the register whose index is the low 4 bits of register r.
- R6: Bit operations use bit index b = opcode[2:0]. 0x4_ sets accumulator bit b when opcode[3]=0 and clears it when opcode[3]=1. 0x5_ skips when bit b is 1 (opcode[3]=0) or when it is 0 (opcode[3]=1).
- R7: 0x3r skips when the accumulator equals register r. 0xEr skips when the accumulator is unsigned less than or equal to register r. A taken skip leaves the PC three past the skip opcode, so it passes over two bytes. An untaken skip leaves it one past.
- R8: 0x7d is an output to device d and 0x6d is an input from device d. In the execute clock, `dev_sel` shows d and `io_wr` or `io_rd` is high, and an input loads `io_din` into the accumulator. For d = 0 no strobe is raised and the accumulator is kept. Outside that clock `dev_sel` is 0 and the strobes are low.
- R9: With pin index p = opcode[2:0], 0xC_ sets `dctl_out[p]` when opcode[3]=0 and clears it when opcode[3]=1. 0xD_ skips when (`dctl_out[p]` OR `dctl_in[p]`) is 1 (opcode[3]=0) or is 0 (opcode[3]=1).
- R10: 0x8h,lo jumps to {h[2:0],lo}. When h[3]=1 it also saves the address after the operand in the one-entry subroutine slot. 0x06 returns to the saved address.
- R11: A high `irq` with interrupts unmasked is taken only after an execute clock. It costs one extra clock, saves the next PC, masks interrupts and sets the PC to ISR_VEC (default 0x7F0). 0x07 restores the saved PC and unmasks.
- R12: While interrupts are masked, `irq` has no effect on the program flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | 11 | Instruction memory address (program counter) |
| rom_data | input | 8 | Instruction memory data, valid in the same cycle |
| irq | input | 1 | Interrupt request, level |
| dev_sel | output | 4 | Selected device, 0 when none |
| io_rd | output | 1 | Input strobe |
| io_wr | output | 1 | Output strobe |
| io_dout | output | 8 | Accumulator value, written to devices |
| io_din | input | 8 | Data read from devices |
| dctl_out | output | 8 | Direct control pin latches |
| dctl_in | input | 8 | External drive seen on the control pins |

## Verification
The hardest case to reach from the ports is an interrupt that stays high after it has been taken: the mask alone has to keep the handler from re-entering. The stimulus holds `irq` high from reset through the handler's first instruction. It checks that the PC steps through the handler instead of jumping back to the vector. It then lowers `irq` and checks that the return instruction lands on the interrupted address. Indexed loads are reached by storing a pointer in one register and a value in the register it points at.

// File: rtl/acr_pkg.sv
package acr_pkg;
    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_INTR
    } acr_state_t;

    // opcode groups (upper nibble)
    localparam logic [3:0] G_MISC = 4'h0;
    localparam logic [3:0] G_LDR  = 4'h1;
    localparam logic [3:0] G_STR  = 4'h2;
    localparam logic [3:0] G_SEQ  = 4'h3;
    localparam logic [3:0] G_BIT  = 4'h4;
    localparam logic [3:0] G_BTST = 4'h5;
    localparam logic [3:0] G_IN   = 4'h6;
    localparam logic [3:0] G_OUT  = 4'h7;
    localparam logic [3:0] G_JMP  = 4'h8;
    localparam logic [3:0] G_LDI  = 4'h9;
    localparam logic [3:0] G_LDA  = 4'hA;
    localparam logic [3:0] G_LDX  = 4'hB;
    localparam logic [3:0] G_PIN  = 4'hC;
    localparam logic [3:0] G_PTST = 4'hD;
    localparam logic [3:0] G_SLE  = 4'hE;
endpackage

// File: rtl/acr_regbank.sv
module acr_regbank #(
    parameter int DATA_W = 8,
    parameter int NREG   = 16,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[i] <= '0;
            else if (we && waddr == IDX_W'(i))
                mem_q[i] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/acr_retslot.sv
module acr_retslot #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end

    // R10 / R11: a single entry changes only when written
    p_slot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
    p_slot_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(din));
endmodule

// File: rtl/ioctl_core.sv
module ioctl_core
    import acr_pkg::*;
#(
    parameter int              PC_W    = 11,
    parameter int              DATA_W  = 8,
    parameter int              NREG    = 16,
    parameter int              DEV_W   = 4,
    parameter int              DCTL_W  = 8,
    parameter logic [PC_W-1:0] ISR_VEC = 11'h7F0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    input  logic              irq,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              io_rd,
    output logic              io_wr,
    output logic [DATA_W-1:0] io_dout,
    input  logic [DATA_W-1:0] io_din,
    output logic [DCTL_W-1:0] dctl_out,
    input  logic [DCTL_W-1:0] dctl_in
);
    localparam int RIDX_W = $clog2(NREG);
    localparam int BIDX_W = $clog2(DATA_W);
    localparam int PIDX_W = $clog2(DCTL_W);
    localparam int HI_W   = PC_W - DATA_W;

    acr_state_t        st_q, st_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [DATA_W-1:0] ir_q, ir_d;
    logic [DATA_W-1:0] acc_q, acc_d;
    logic [DCTL_W-1:0] pins_q, pins_d;
    logic              imask_q, imask_d;

    logic [3:0]        grp;
    logic [BIDX_W-1:0] bidx;
    logic [PIDX_W-1:0] pidx;
    logic [DEV_W-1:0]  dev;
    logic              skip, io_grp;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wd, rd_a, rd_b;
    logic              sstk_ld, istk_ld;
    logic [PC_W-1:0]   sstk_q, istk_q;

    assign grp  = ir_q[DATA_W-1:DATA_W-4];
    assign bidx = ir_q[BIDX_W-1:0];
    assign pidx = ir_q[PIDX_W-1:0];
    assign dev  = ir_q[DEV_W-1:0];

    acr_regbank #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (ir_q[RIDX_W-1:0]),
        .wdata   (rf_wd),
        .raddr_a (ir_q[RIDX_W-1:0]),
        .rdata_a (rd_a),
        .raddr_b (rd_a[RIDX_W-1:0]),
        .rdata_b (rd_b)
    );

    acr_retslot #(.W(PC_W)) u_sub_slot (
        .clk (clk), .rst_n (rst_n), .load (sstk_ld),
        .din (pc_q + PC_W'(1)), .dout (sstk_q)
    );

    acr_retslot #(.W(PC_W)) u_int_slot (
        .clk (clk), .rst_n (rst_n), .load (istk_ld),
        .din (pc_q), .dout (istk_q)
    );

    // next state and datapath
    always_comb begin
        st_d    = st_q;
        pc_d    = pc_q;
        ir_d    = ir_q;
        acc_d   = acc_q;
        pins_d  = pins_q;
        imask_d = imask_q;
        rf_we   = 1'b0;
        rf_wd   = acc_q;
        sstk_ld = 1'b0;
        istk_ld = 1'b0;
        skip    = 1'b0;
        unique case (st_q)
            ST_FETCH: begin
                ir_d = rom_data;
                pc_d = pc_q + PC_W'(1);
                st_d = ST_EXEC;
            end
            ST_INTR: begin
                istk_ld = 1'b1;
                imask_d = 1'b1;
                pc_d    = ISR_VEC;
                st_d    = ST_FETCH;
            end
            ST_EXEC: begin
                st_d = (irq && !imask_q) ? ST_INTR : ST_FETCH;
                case (grp)
                    G_MISC: begin
                        case (ir_q[3:0])
                            4'h1: acc_d = acc_q + DATA_W'(1);
                            4'h2: acc_d = acc_q - DATA_W'(1);
                            4'h3: acc_d = acc_q << 1;
                            4'h4: acc_d = acc_q >> 1;
                            4'h5: acc_d = ~acc_q;
                            4'h6: pc_d  = sstk_q;
                            4'h7: begin
                                pc_d    = istk_q;
                                imask_d = 1'b0;
                            end
                            default: ;
                        endcase
                    end
                    G_LDR:  acc_d = rd_a;
                    G_STR:  rf_we = 1'b1;
                    G_SEQ:  skip  = (acc_q == rd_a);
                    G_BIT:  acc_d[bidx] = ~ir_q[3];
                    G_BTST: skip  = acc_q[bidx] ^ ir_q[3];
                    G_IN:   if (dev != '0) acc_d = io_din;
                    G_JMP: begin
                        pc_d    = {ir_q[HI_W-1:0], rom_data};
                        sstk_ld = ir_q[3];
                    end
                    G_LDI: begin
                        rf_we = 1'b1;
                        rf_wd = rom_data;
                        pc_d  = pc_q + PC_W'(1);
                    end
                    G_LDA: begin
                        acc_d = rom_data;
                        pc_d  = pc_q + PC_W'(1);
                    end
                    G_LDX:  acc_d = rd_b;
                    G_PIN:  pins_d[pidx] = ~ir_q[3];
                    G_PTST: skip = (pins_q[pidx] | dctl_in[pidx]) ^ ir_q[3];
                    G_SLE:  skip = (acc_q <= rd_a);
                    default: ;
                endcase
                if (skip)
                    pc_d = pc_q + PC_W'(2);
            end
            default: st_d = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            acc_q   <= '0;
            pins_q  <= '0;
            imask_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            pc_q    <= pc_d;
            ir_q    <= ir_d;
            acc_q   <= acc_d;
            pins_q  <= pins_d;
            imask_q <= imask_d;
        end
    end

    // outputs
    always_comb begin
        io_grp   = (st_q == ST_EXEC) && (grp == G_IN || grp == G_OUT);
        dev_sel  = io_grp ? dev : '0;
        io_rd    = io_grp && grp == G_IN  && dev != '0;
        io_wr    = io_grp && grp == G_OUT && dev != '0;
        io_dout  = acc_q;
        dctl_out = pins_q;
        rom_addr = pc_q;
    end

    p_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_FETCH |=> st_q == ST_EXEC);
    p_fetch_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_FETCH |=> pc_q == $past(pc_q) + PC_W'(1));
    p_strobe_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> (dev_sel != '0 && st_q == ST_EXEC));
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr}));
    p_vector_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_INTR |=> (pc_q == ISR_VEC && imask_q && st_q == ST_FETCH));
    p_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_INTR |-> $past(st_q) == ST_EXEC);
    p_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_INTR |-> !imask_q);
endmodule

// File: tb/ioctl_core_tb.sv
module ioctl_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [10:0] VEC = 11'h7F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] rom_addr;
    logic [7:0]  rom_data;
    logic        irq = 1'b0;
    logic [3:0]  dev_sel;
    logic        io_rd, io_wr;
    logic [7:0]  io_dout;
    logic [7:0]  io_din = 8'h00;
    logic [7:0]  dctl_out;
    logic [7:0]  dctl_in = 8'h00;
    logic [7:0]  rom [0:2047];
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign rom_data = rom[rom_addr];

    ioctl_core u_dut (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .irq(irq), .dev_sel(dev_sel), .io_rd(io_rd), .io_wr(io_wr),
        .io_dout(io_dout), .io_din(io_din), .dctl_out(dctl_out), .dctl_in(dctl_in)
    );

    // {init acc, opcode, expected acc, expected pc}
    localparam logic [31:0] VECS [15] = '{
        {8'h7F, 8'h01, 8'h80, 8'd3},   // R4 inc
        {8'hFF, 8'h01, 8'h00, 8'd3},   // R4 inc wrap
        {8'h00, 8'h02, 8'hFF, 8'd3},   // R4 dec wrap
        {8'h81, 8'h03, 8'h02, 8'd3},   // R4 shl
        {8'h81, 8'h04, 8'h40, 8'd3},   // R4 shr
        {8'hA5, 8'h05, 8'h5A, 8'd3},   // R4 cpl
        {8'h00, 8'h43, 8'h08, 8'd3},   // R6 set bit3
        {8'hFF, 8'h4F, 8'h7F, 8'd3},   // R6 clear bit7
        {8'h04, 8'h52, 8'h04, 8'd5},   // R6 skip bit2 set
        {8'h00, 8'h52, 8'h00, 8'd3},   // R6 no skip
        {8'h00, 8'h5A, 8'h00, 8'd5},   // R6 skip bit2 clear
        {8'h00, 8'h30, 8'h00, 8'd5},   // R7 equal skip
        {8'h01, 8'h30, 8'h01, 8'd3},   // R7 not equal
        {8'h00, 8'hE0, 8'h00, 8'd5},   // R7 le skip
        {8'h01, 8'hE0, 8'h01, 8'd3}    // R7 greater
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 2048; i++) rom[i] = 8'hF0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_rom();
        do_reset();
        // R1 reset state
        check("R1 rom_addr", rom_addr, 0);
        check("R1 acc", io_dout, 0);
        check("R1 pins", dctl_out, 0);
        check("R1 dev_sel", dev_sel, 0);
        check("R1 strobes", {io_rd, io_wr}, 0);
        // R2 fetch advances, one-byte execute holds PC
        step(1);
        check("R2 fetch advance", rom_addr, 1);
        step(1);
        check("R2 exec hold", rom_addr, 1);

        // table walk: R4 R6 R7
        foreach (VECS[k]) begin
            clear_rom();
            rom[0] = 8'hA0;
            rom[1] = VECS[k][31:24];
            rom[2] = VECS[k][23:16];
            do_reset();
            step(4);
            check($sformatf("R4/R6/R7 vec%0d acc", k), io_dout, VECS[k][15:8]);
            check($sformatf("R6/R7 vec%0d pc", k), rom_addr, VECS[k][7:0]);
        end

        // R5 register access and indexed load
        clear_rom();
        rom[0] = 8'hA0; rom[1] = 8'h07; rom[2] = 8'h25;
        rom[3] = 8'hA0; rom[4] = 8'h05; rom[5] = 8'h22;
        rom[6] = 8'hA0; rom[7] = 8'h00; rom[8] = 8'hB2;
        rom[9] = 8'h9A; rom[10] = 8'h3C; rom[11] = 8'h1A;
        do_reset();
        step(12);
        check("R5 indexed load", io_dout, 8'h07);
        step(4);
        check("R5 immediate to register then load", io_dout, 8'h3C);
        check("R3 pc after two-byte", rom_addr, 12);

        // R8 device I/O
        clear_rom();
        rom[0] = 8'hA0; rom[1] = 8'h5A; rom[2] = 8'h73; rom[3] = 8'h64; rom[4] = 8'h60;
        do_reset();
        step(2);
        check("R8 idle dev_sel", dev_sel, 0);
        step(1);
        check("R8 out dev_sel", dev_sel, 3);
        check("R8 out strobes", {io_rd, io_wr}, 2'b01);
        check("R8 out data", io_dout, 8'h5A);
        io_din = 8'hC3;
        step(1);
        check("R8 strobes off in fetch", {io_rd, io_wr}, 0);
        step(1);
        check("R8 in dev_sel", dev_sel, 4);
        check("R8 in strobes", {io_rd, io_wr}, 2'b10);
        step(1);
        check("R8 in data", io_dout, 8'hC3);
        io_din = 8'h11;
        step(1);
        check("R8 device0 no strobe", {io_rd, io_wr, dev_sel}, 0);
        step(1);
        check("R8 device0 acc kept", io_dout, 8'hC3);

        // R9 direct control pins
        clear_rom();
        rom[0] = 8'hC2; rom[1] = 8'hD2; rom[4] = 8'hCA; rom[5] = 8'hD5;
        do_reset();
        step(2);
        check("R9 pin set", dctl_out, 8'h04);
        step(2);
        check("R9 test own latch skip", rom_addr, 4);
        step(2);
        check("R9 pin clear", dctl_out, 8'h00);
        dctl_in = 8'h20;
        step(2);
        check("R9 test external input skip", rom_addr, 8);
        dctl_in = 8'h00;

        // R10 jump, call, return
        clear_rom();
        rom[0] = 8'h83; rom[1] = 8'h21;
        rom[11'h321] = 8'h8C; rom[11'h322] = 8'h40;
        rom[11'h440] = 8'h06;
        do_reset();
        step(2);
        check("R10 jump / R3 two clocks", rom_addr, 11'h321);
        step(2);
        check("R10 call", rom_addr, 11'h440);
        step(2);
        check("R10 return", rom_addr, 11'h323);

        // R11 R12 interrupt entry, masking, return
        clear_rom();
        rom[VEC + 11'd2] = 8'h07;
        irq = 1'b1;
        do_reset();
        step(2);
        check("R11 not taken mid instruction", rom_addr, 1);
        step(1);
        check("R11 vector", rom_addr, VEC);
        step(2);
        check("R12 masked no reentry", rom_addr, VEC + 11'd1);
        irq = 1'b0;
        step(4);
        check("R11 return from interrupt", rom_addr, 1);
        irq = 1'b1;
        step(3);
        check("R11 unmasked after return", rom_addr, VEC);
        irq = 1'b0;

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule